// File: doc/BRIEF.md
# Paired Byte Register File

This block keeps the seven general byte registers of a small 8-bit processor core: an accumulator and six registers that also combine, two at a time, into three 16-bit pairs. One operation is offered per cycle through an operation code, register and pair selectors, two immediate bytes and a direct address. Most operations finish in the cycle they are accepted. These cover byte moves and byte loads, pair loads, an in-place exchange of two pairs, 16-bit increment and decrement, and a 16-bit add into the pointer pair.

Two operations move the pointer pair to and from a synchronous byte memory in two beats. One fetches the low register from a direct address and the high register from the next address. The other writes the low register first and the high register second. While such a transfer runs, the block reports itself busy and accepts nothing new. The pointer pair is always driven out as a 16-bit address for indirect accesses made elsewhere in the core. A combinational read port returns any single register.

Top module: `regpair_file`

## Requirements
- R1: After reset every register reads 0x00, `hlPtr` is 0x0000, `carryFlag` and `carryStb` are 0, and `busy` and `memReq` are low.
- R2: Register selector codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7. Code 6 names no register: it always reads 0x00 and writes to it have no effect. The move operation (opCode 1) copies the `srcSel` register into the `dstSel` register and leaves the source unchanged.
- R3: The byte load (opCode 2) writes `immLo` into the `dstSel` register.
- R4: The pair load (opCode 3) writes `immHi` into the high register of the pair and `immLo` into the low register. Pair selector codes are B-C=0, D-E=1, H-L=2; code 3 has no effect.
- R5: The exchange (opCode 4) swaps H with D and L with E in the same cycle.
- R6: Pair increment (opCode 5) and decrement (opCode 6) treat the pair as one 16-bit value that wraps modulo 65536. They leave `carryFlag` unchanged.
- R7: The pair add (opCode 7) writes H-L plus the selected pair, modulo 65536, into H-L. `carryFlag` takes the carry out of bit 15. `carryStb` is high for exactly the one cycle after each accepted add.
- R8: The direct load (opCode 8) issues reads at `dirAddr` and then at `dirAddr`+1 (wrapping at 16 bits) in consecutive cycles. The first returned byte goes into L and the second into H.
- R9: The direct store (opCode 9) writes L at `dirAddr` and then H at `dirAddr`+1 (wrapping at 16 bits) in consecutive cycles, with `memWe` high.
- R10: `busy` is high for three cycles after a direct load is accepted and for two cycles after a direct store is accepted. Operations presented while `busy` is high are ignored, and `memReq` is never high unless `busy` is high.
- R11: `hlPtr` always shows {H, L}, and opCodes 0 and 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| dstSel | input | 3 | Destination register selector |
| srcSel | input | 3 | Source register selector |
| pairSel | input | 2 | Pair selector |
| immLo | input | 8 | Immediate byte, low |
| immHi | input | 8 | Immediate byte, high |
| dirAddr | input | 16 | Direct address for the two-beat transfers |
| rdSel | input | 3 | Read port selector |
| rdData | output | 8 | Read port data, combinational |
| hlPtr | output | 16 | Current H-L pair |
| carryStb | output | 1 | One-cycle pulse after a pair add |
| carryFlag | output | 1 | Carry out of the last pair add |
| busy | output | 1 | A two-beat transfer is in progress |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after a read request |

## Verification
Register results, `hlPtr` and `carryStb` all come from the edge that accepts the operation. The bench therefore presents each operation at a falling edge, withdraws it one falling edge later and samples at that same falling edge. `carryStb` is sampled once there and again one cycle later, when it must be low. For the two-beat transfers, the bench counts the falling edges at which `busy` is still high and expects three for a load and two for a store. Memory requests are logged by a model that returns read data one edge after each request, and the registers and the logged addresses are checked only once `busy` has dropped.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_MOV  = 4'd1,
    OP_LDI  = 4'd2,
    OP_LDP  = 4'd3,
    OP_SWAP = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_ADD  = 4'd7,
    OP_LDHL = 4'd8,
    OP_STHL = 4'd9
  } opKind_e;

  // register selector codes
  localparam logic [2:0] SEL_B    = 3'd0;
  localparam logic [2:0] SEL_C    = 3'd1;
  localparam logic [2:0] SEL_D    = 3'd2;
  localparam logic [2:0] SEL_E    = 3'd3;
  localparam logic [2:0] SEL_H    = 3'd4;
  localparam logic [2:0] SEL_L    = 3'd5;
  localparam logic [2:0] SEL_NONE = 3'd6;
  localparam logic [2:0] SEL_A    = 3'd7;

  localparam int NUM_SLOTS = 8;

  // control to datapath strobes
  typedef struct packed {
    logic movEn;
    logic immEn;
    logic pairLdEn;
    logic swapEn;
    logic incEn;
    logic decEn;
    logic addEn;
    logic memLoLd;
    logic memHiLd;
  } dpStrobe_t;

endpackage

// File: rtl/rpf_ctrl.sv
module rpf_ctrl
  import rpf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [AW-1:0]     dirAddr,
  input  logic [2*DW-1:0]   hlPair,
  output dpStrobe_t         stb,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_LD0, S_LD1, S_LD2, S_ST0, S_ST1
  } xferState_e;

  xferState_e stateQ, stateD;
  logic [AW-1:0] addrQ;
  logic accept;
  opKind_e opK;

  assign opK    = opKind_e'(opCode);
  assign accept = opValid && (stateQ == S_IDLE);
  assign busy   = (stateQ != S_IDLE);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (accept && opK == OP_LDHL)      stateD = S_LD0;
        else if (accept && opK == OP_STHL) stateD = S_ST0;
      end
      S_LD0:   stateD = S_LD1;
      S_LD1:   stateD = S_LD2;
      S_LD2:   stateD = S_IDLE;
      S_ST0:   stateD = S_ST1;
      S_ST1:   stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      addrQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (accept && (opK == OP_LDHL || opK == OP_STHL)) addrQ <= dirAddr;
    end
  end

  always_comb begin
    stb          = '0;
    stb.movEn    = accept && opK == OP_MOV;
    stb.immEn    = accept && opK == OP_LDI;
    stb.pairLdEn = accept && opK == OP_LDP;
    stb.swapEn   = accept && opK == OP_SWAP;
    stb.incEn    = accept && opK == OP_INC;
    stb.decEn    = accept && opK == OP_DEC;
    stb.addEn    = accept && opK == OP_ADD;
    stb.memLoLd  = (stateQ == S_LD1);
    stb.memHiLd  = (stateQ == S_LD2);
  end

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWdata = '0;
    case (stateQ)
      S_LD0: begin memReq = 1'b1; memAddr = addrQ; end
      S_LD1: begin memReq = 1'b1; memAddr = addrQ + 1'b1; end
      S_ST0: begin
        memReq = 1'b1; memWe = 1'b1; memAddr = addrQ;
        memWdata = hlPair[DW-1:0];
      end
      S_ST1: begin
        memReq = 1'b1; memWe = 1'b1; memAddr = addrQ + 1'b1;
        memWdata = hlPair[2*DW-1:DW];
      end
      default: ;
    endcase
  end

  // R10: memory is only touched during a transfer
  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R8 / R9: second beat address follows the first
  p_next_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_LD1 || stateQ == S_ST1) |-> memAddr == AW'($past(memAddr) + 1'b1));

  // R10: load keeps busy three cycles
  p_load_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opK == OP_LDHL) |=> busy ##1 busy ##1 busy ##1 !busy);

  // R9: store keeps busy two cycles with writes
  p_store_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && opK == OP_STHL) |=> (busy && memWe) ##1 (busy && memWe) ##1 !busy);

endmodule

// File: rtl/rpf_datapath.sv
module rpf_datapath
  import rpf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [2:0]        dstSel,
  input  logic [2:0]        srcSel,
  input  logic [1:0]        pairSel,
  input  logic [DW-1:0]     immLo,
  input  logic [DW-1:0]     immHi,
  input  logic [DW-1:0]     memRdata,
  input  logic [2:0]        rdSel,
  output logic [DW-1:0]     rdData,
  output logic [2*DW-1:0]   hlPair,
  output logic              carryStb,
  output logic              carryFlag
);

  localparam int PW = 2 * DW;

  logic [DW-1:0] regQ [NUM_SLOTS];
  logic [DW-1:0] regD [NUM_SLOTS];

  logic [2:0]    hiIdx, loIdx;
  logic          pairOk;
  logic [PW-1:0] selPair, stepPair;
  logic [PW:0]   sumWide;
  logic [PW-1:0] dePair;

  assign pairOk = (pairSel != 2'd3);

  always_comb begin
    unique case (pairSel)
      2'd0:    begin hiIdx = SEL_B; loIdx = SEL_C; end
      2'd1:    begin hiIdx = SEL_D; loIdx = SEL_E; end
      default: begin hiIdx = SEL_H; loIdx = SEL_L; end
    endcase
  end

  assign selPair = {regQ[hiIdx], regQ[loIdx]};
  assign hlPair  = {regQ[SEL_H], regQ[SEL_L]};
  assign dePair  = {regQ[SEL_D], regQ[SEL_E]};
  assign stepPair = stb.decEn ? (selPair - 1'b1) : (selPair + 1'b1);
  assign sumWide  = {1'b0, hlPair} + {1'b0, selPair};
  assign rdData   = regQ[rdSel];

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) regD[i] = regQ[i];
    if (stb.movEn) regD[dstSel] = regQ[srcSel];
    if (stb.immEn) regD[dstSel] = immLo;
    if (stb.pairLdEn && pairOk) begin
      regD[hiIdx] = immHi;
      regD[loIdx] = immLo;
    end
    if (stb.swapEn) begin
      regD[SEL_H] = regQ[SEL_D];
      regD[SEL_L] = regQ[SEL_E];
      regD[SEL_D] = regQ[SEL_H];
      regD[SEL_E] = regQ[SEL_L];
    end
    if ((stb.incEn || stb.decEn) && pairOk) begin
      regD[hiIdx] = stepPair[PW-1:DW];
      regD[loIdx] = stepPair[DW-1:0];
    end
    if (stb.addEn && pairOk) begin
      regD[SEL_H] = sumWide[PW-1:DW];
      regD[SEL_L] = sumWide[DW-1:0];
    end
    if (stb.memLoLd) regD[SEL_L] = memRdata;
    if (stb.memHiLd) regD[SEL_H] = memRdata;
  end

  // one storage slot per selector code; code 6 has no storage
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == int'(SEL_NONE)) begin : g_empty
      assign regQ[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[g] <= '0;
        else       regQ[g] <= regD[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryStb  <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      carryStb <= stb.addEn && pairOk;
      if (stb.addEn && pairOk) carryFlag <= sumWide[PW];
    end
  end

  // R5: exchange of the two pairs
  p_swap_pairs_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.swapEn |=> (hlPair == $past(dePair)) && (dePair == $past(hlPair)));

  // R6: pointer pair increment wraps
  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incEn && pairSel == 2'd2) |=> hlPair == PW'($past(hlPair) + 1'b1));

  // R6: step operations keep the carry
  p_step_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incEn || stb.decEn) |=> $stable(carryFlag));

  // R7: carry strobe only after an add
  p_carry_after_add_r7: assert property (@(posedge clk) disable iff (!rstN)
    carryStb |-> $past(stb.addEn));

endmodule

// File: rtl/regpair_file.sv
module regpair_file
  import rpf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [3:0]      opCode,
  input  logic [2:0]      dstSel,
  input  logic [2:0]      srcSel,
  input  logic [1:0]      pairSel,
  input  logic [DW-1:0]   immLo,
  input  logic [DW-1:0]   immHi,
  input  logic [AW-1:0]   dirAddr,
  input  logic [2:0]      rdSel,
  output logic [DW-1:0]   rdData,
  output logic [2*DW-1:0] hlPtr,
  output logic            carryStb,
  output logic            carryFlag,
  output logic            busy,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata
);

  dpStrobe_t stb;
  logic [2*DW-1:0] hlPair;

  assign hlPtr = hlPair;

  rpf_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .dirAddr(dirAddr), .hlPair(hlPair), .stb(stb), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  rpf_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dstSel(dstSel), .srcSel(srcSel),
    .pairSel(pairSel), .immLo(immLo), .immHi(immHi), .memRdata(memRdata),
    .rdSel(rdSel), .rdData(rdData), .hlPair(hlPair),
    .carryStb(carryStb), .carryFlag(carryFlag)
  );

endmodule

// File: tb/sim_regpair_file.sv
module sim_regpair_file;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [2:0] dstSel = '0, srcSel = '0, rdSel = '0;
  logic [1:0] pairSel = '0;
  logic [7:0] immLo = '0, immHi = '0;
  logic [15:0] dirAddr = '0;
  logic [7:0] rdData, memWdata;
  logic [7:0] memRdata = '0;
  logic [15:0] hlPtr, memAddr;
  logic carryStb, carryFlag, busy, memReq, memWe;

  int nChk = 0, nBad = 0;
  logic [7:0] mem [256];
  logic [15:0] reqLog [8];
  int reqCnt = 0;

  always #10 clk = ~clk;

  regpair_file u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .dstSel(dstSel), .srcSel(srcSel), .pairSel(pairSel), .immLo(immLo),
    .immHi(immHi), .dirAddr(dirAddr), .rdSel(rdSel), .rdData(rdData),
    .hlPtr(hlPtr), .carryStb(carryStb), .carryFlag(carryFlag), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // synchronous byte memory, indexed by the low address byte
  always @(posedge clk) begin
    if (memReq) begin
      if (reqCnt < 8) reqLog[reqCnt] = memAddr;
      reqCnt = reqCnt + 1;
      if (memWe) mem[memAddr[7:0]] <= memWdata;
      else       memRdata <= mem[memAddr[7:0]];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    rdSel = s;
    #1 v = rdData;
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] d, input logic [2:0] s,
                       input logic [1:0] p, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [15:0] a);
    @(negedge clk);
    opValid = 1'b1; opCode = op; dstSel = d; srcSel = s; pairSel = p;
    immLo = lo; immHi = hi; dirAddr = a;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1", "reg after reset", v, 0);
    end
    chk("R1", "hlPtr", hlPtr, 0);
    chk("R1", "carry/busy/req", {carryFlag, carryStb, busy, memReq}, 0);
  endtask

  task automatic t_moves;
    logic [7:0] v;
    issue(4'd2, 3'd7, 0, 0, 8'h87, 0, 0);   // A = 87
    rd(3'd7, v); chk("R3", "byte load A", v, 8'h87);
    issue(4'd2, 3'd1, 0, 0, 8'h55, 0, 0);   // C = 55
    issue(4'd1, 3'd1, 3'd7, 0, 0, 0, 0);    // C <- A
    rd(3'd1, v); chk("R2", "move dest C", v, 8'h87);
    rd(3'd7, v); chk("R2", "move source A kept", v, 8'h87);
    issue(4'd2, 3'd6, 0, 0, 8'h5A, 0, 0);   // write to empty code
    rd(3'd6, v); chk("R2", "code 6 reads zero", v, 0);
    rd(3'd7, v); chk("R2", "A untouched by code 6", v, 8'h87);
    issue(4'd12, 3'd7, 0, 0, 8'h11, 8'h22, 0); // unused opcode
    rd(3'd7, v); chk("R11", "unused opcode no effect", v, 8'h87);
  endtask

  task automatic t_pairs;
    logic [7:0] v;
    issue(4'd3, 0, 0, 2'd0, 8'h00, 8'hD5, 0);
    rd(3'd0, v); chk("R4", "pair load B", v, 8'hD5);
    rd(3'd1, v); chk("R4", "pair load C", v, 8'h00);
    issue(4'd3, 0, 0, 2'd3, 8'h99, 8'h99, 0);
    rd(3'd0, v); chk("R4", "pair code 3 no effect", v, 8'hD5);
    issue(4'd3, 0, 0, 2'd2, 8'h35, 8'h28, 0);
    chk("R11", "hlPtr after load", hlPtr, 16'h2835);
    issue(4'd3, 0, 0, 2'd1, 8'h22, 8'h45, 0);
    issue(4'd4, 0, 0, 0, 0, 0, 0);
    chk("R5", "H-L after swap", hlPtr, 16'h4522);
    rd(3'd2, v); chk("R5", "D after swap", v, 8'h28);
    rd(3'd3, v); chk("R5", "E after swap", v, 8'h35);
  endtask

  task automatic t_step_add;
    logic [7:0] v;
    issue(4'd3, 0, 0, 2'd2, 8'h50, 8'hF0, 0);
    issue(4'd5, 0, 0, 2'd2, 0, 0, 0);
    chk("R6", "inc F050", hlPtr, 16'hF051);
    issue(4'd6, 0, 0, 2'd2, 0, 0, 0);
    issue(4'd6, 0, 0, 2'd2, 0, 0, 0);
    chk("R6", "dec to F04F", hlPtr, 16'hF04F);
    issue(4'd3, 0, 0, 2'd1, 8'hFF, 8'hFF, 0);
    issue(4'd5, 0, 0, 2'd1, 0, 0, 0);
    rd(3'd2, v); chk("R6", "inc FFFF wraps D", v, 0);
    issue(4'd6, 0, 0, 2'd1, 0, 0, 0);
    rd(3'd3, v); chk("R6", "dec 0000 wraps E", v, 8'hFF);
    // add with carry out
    issue(4'd3, 0, 0, 2'd2, 8'h00, 8'hF0, 0);
    issue(4'd3, 0, 0, 2'd0, 8'h00, 8'h20, 0);
    issue(4'd7, 0, 0, 2'd0, 0, 0, 0);
    chk("R7", "add sum", hlPtr, 16'h1000);
    chk("R7", "carry set, strobe", {carryFlag, carryStb}, 2'b11);
    @(negedge clk);
    chk("R7", "strobe one cycle", carryStb, 0);
    issue(4'd5, 0, 0, 2'd0, 0, 0, 0);
    chk("R6", "inc keeps carry", carryFlag, 1);
    issue(4'd3, 0, 0, 2'd1, 8'h00, 8'h01, 0);
    issue(4'd7, 0, 0, 2'd1, 0, 0, 0);
    chk("R7", "add no carry", {hlPtr, carryFlag}, {16'h1100, 1'b0});
  endtask

  task automatic t_mem;
    int n;
    logic [7:0] v;
    mem[8'h50] = 8'h28; mem[8'h51] = 8'h66;
    reqCnt = 0;
    issue(4'd8, 0, 0, 0, 0, 0, 16'hC050);
    waitIdle(n);
    chk("R10", "load busy cycles", n, 3);
    chk("R8", "direct load H-L", hlPtr, 16'h6628);
    chk("R8", "load addresses", {reqLog[0], reqLog[1]}, {16'hC050, 16'hC051});
    // store with address wrap
    issue(4'd3, 0, 0, 2'd2, 8'h89, 8'h34, 0);
    reqCnt = 0;
    issue(4'd9, 0, 0, 0, 0, 0, 16'hFFFF);
    waitIdle(n);
    chk("R10", "store busy cycles", n, 2);
    chk("R9", "store addresses", {reqLog[0], reqLog[1]}, {16'hFFFF, 16'h0000});
    chk("R9", "stored bytes", {mem[8'hFF], mem[8'h00]}, {8'h89, 8'h34});
    // load with wrap and an op presented while busy
    mem[8'hFF] = 8'hAB; mem[8'h00] = 8'hCD;
    issue(4'd2, 3'd0, 0, 0, 8'h11, 0, 0);     // B = 11
    issue(4'd8, 0, 0, 0, 0, 0, 16'hFFFF);
    opValid = 1'b1; opCode = 4'd2; dstSel = 3'd0; immLo = 8'h77;
    @(negedge clk);
    opValid = 1'b0;
    waitIdle(n);
    chk("R8", "wrapped load H-L", hlPtr, 16'hCDAB);
    rd(3'd0, v); chk("R10", "op while busy ignored", v, 8'h11);
    chk("R10", "no request when idle", memReq, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_moves();
    t_pairs();
    t_step_add();
    t_mem();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #2000000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule